// File: doc/BRIEF.md
# Phase-Locked Bus Cycle Sequencer

This block lets a card act as bus master on a legacy 8-bit expansion bus. The bus supplies two clocks: a fast reference clock and a slower phase clock whose halves each span a fixed number of reference-clock edges. The sequencer runs on its own, much faster card clock. Both bus clocks pass through synchronizers into the card clock domain. A position counter then steps on every reference edge, rising or falling, and restarts on every phase edge, so every point inside a bus cycle has a number.

A client hands the sequencer one transfer at a time: an address, a write flag and write data. The transfer is accepted only at a phase rising edge. The sequencer raises its bus-master request at that edge. It places address and direction during the following low half and runs the transfer in the high half after that. On a read it samples the data bus one position before the phase clock falls. On a write it keeps the data drivers on for a set margin past the fall. The bus-master request is dropped at the next phase rise.

Top module: `bus_cycle_seq`

## Requirements
- R1: The position counter steps on both reference-clock edges and restarts at each phase edge. Inside the high half, the read sample strobe `cap_stb` fires at position CAP_TICK (default 6, the last reference edge before the fall). The write enable opens at position WR_TICK (default 1).
- R2: `bus_mreq` changes state only within 200 ns after a phase rising edge. It is active low by default. It goes active at the accepting rise and inactive at the rise that follows the transfer's high half. It stays active whenever the address is driven.
- R3: `bus_addr_o`, `bus_rw_n` (1 = read, 0 = write) and `bus_addr_oe` change only while the phase clock is low. They hold steady through the whole high half of the transfer.
- R4: On a write, `bus_data_oe` rises at WR_TICK of the high half and stays high through the phase fall. It then stays high for at least HOLD_NS (default 80 ns) and drops before the next rise. On a read it never rises.
- R5: A read returns, on `rd_data_o`, the value present on `bus_rdata_i` just before the phase fall. Values placed on the bus after the fall are not taken.
- R6: `done_o` pulses for one card clock exactly one clock after `cap_stb`, for reads and writes alike.
- R7: A request is accepted, with a one-cycle `req_ack`, only in response to a phase rising edge while the sequencer is idle. A request raised mid-cycle waits for the next rise.
- R8: After reset: `bus_mreq` inactive (1), `bus_addr_oe` 0, `bus_data_oe` 0, `bus_rw_n` 1, `req_ack` 0, `done_o` 0.
- R9: While `bus_data_oe` is high, `bus_wdata_o` and `bus_addr_o` carry the data and address of the accepted write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Fast reference clock from the bus (asynchronous) |
| phase_i | input | 1 | Phase clock from the bus (asynchronous) |
| req_valid | input | 1 | Client has a transfer waiting |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write data |
| req_ack | output | 1 | One-cycle pulse: request taken |
| done_o | output | 1 | One-cycle pulse: transfer data phase finished |
| rd_data_o | output | DATA_W | Sampled read data |
| bus_mreq | output | 1 | Bus-master request, polarity set by MREQ_ACT_LOW |
| bus_addr_o | output | ADDR_W | Address bus value |
| bus_addr_oe | output | 1 | Address and direction driver enable |
| bus_rw_n | output | 1 | Direction: 1 read, 0 write |
| bus_wdata_o | output | DATA_W | Write data bus value |
| bus_data_oe | output | 1 | Data bus driver enable |
| bus_rdata_i | input | DATA_W | Data bus read value |
| cap_stb | output | 1 | Read sample strobe |

## Verification
Writes go to addresses of distinct high and low bytes, and each is read back. This separates wrong address placement from wrong data sampling. A read of a location never written shows whether the sequencer returns the device's own contents rather than stale captured data. Requests raised in the middle of a high half, and back-to-back requests, show whether acceptance waits for a rise. The bench device replaces read data with its complement right at the fall, so a sample taken after the edge shows up as a wrong value. Timing of each enable, strobe and request edge is measured against the last phase rise. This exposes a counter that misses reference edges or a hold window that is too short.

// File: rtl/bcs_pkg.sv
`timescale 1ns/1ps
package bcs_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_ARM,
      S_SETUP,
      S_BUS,
      S_HOLD,
      S_TAIL
   } seq_state_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/bcs_sync.sv
`timescale 1ns/1ps
module bcs_sync #(
   parameter int N_SIG  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SIG-1:0] async_i,
   output logic [N_SIG-1:0] lvl_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("bcs_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < N_SIG; g++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], async_i[g]};
      end
      assign lvl_o[g] = chain_q[STAGES-1];
   end

endmodule

// File: rtl/bcs_phase_track.sv
`timescale 1ns/1ps
module bcs_phase_track #(
   parameter int TICK_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_lvl,
   input  logic              ph_lvl,
   output logic              ph_hi,
   output logic              ph_rise,
   output logic              ph_fall,
   output logic [TICK_W-1:0] tick_o,
   output logic              tick_stb_o
);
   localparam logic [TICK_W-1:0] TICK_TOP = '1;

   logic ref_prev, ph_prev, ref_edge, ph_edge;
   logic [TICK_W-1:0] tick_q;
   logic stb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_prev <= 1'b0;
         ph_prev  <= 1'b0;
      end else begin
         ref_prev <= ref_lvl;
         ph_prev  <= ph_lvl;
      end
   end

   assign ref_edge = ref_lvl ^ ref_prev;
   assign ph_edge  = ph_lvl ^ ph_prev;
   assign ph_rise  = ph_lvl & ~ph_prev;
   assign ph_fall  = ~ph_lvl & ph_prev;
   assign ph_hi    = ph_lvl;

   // Position counter: phase edges win over reference edges.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q <= '0;
         stb_q  <= 1'b0;
      end else if (ph_edge) begin
         tick_q <= '0;
         stb_q  <= 1'b1;
      end else if (ref_edge) begin
         if (tick_q != TICK_TOP) tick_q <= tick_q + 1'b1;
         stb_q <= 1'b1;
      end else begin
         stb_q <= 1'b0;
      end
   end

   assign tick_o     = tick_q;
   assign tick_stb_o = stb_q;

   a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
      ph_edge |=> (tick_q == '0));

   a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_edge && !ph_edge && tick_q != TICK_TOP) |=> (tick_q == $past(tick_q) + 1'b1));

endmodule

// File: rtl/bcs_cycle_fsm.sv
`timescale 1ns/1ps
module bcs_cycle_fsm
   import bcs_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int TICK_W    = 3,
   parameter int WR_TICK   = 1,
   parameter int CAP_TICK  = 6,
   parameter int HOLD_CLKS = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ph_hi,
   input  logic              ph_rise,
   input  logic              ph_fall,
   input  logic [TICK_W-1:0] tick,
   input  logic              tick_stb,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              req_ack,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              mreq_act,
   output logic [ADDR_W-1:0] addr,
   output logic              addr_oe,
   output logic              rw_n,
   output logic [DATA_W-1:0] wdata,
   output logic              data_oe,
   output logic              cap_stb
);
   localparam int HOLD_W    = (HOLD_CLKS > 1) ? $clog2(HOLD_CLKS) : 1;
   localparam int HOLD_LOAD = (HOLD_CLKS > 0) ? HOLD_CLKS - 1 : 0;
   localparam logic [TICK_W-1:0] WR_POS  = TICK_W'(WR_TICK);
   localparam logic [TICK_W-1:0] CAP_POS = TICK_W'(CAP_TICK);

   seq_state_e state;
   logic [ADDR_W-1:0] lat_addr, addr_q;
   logic [DATA_W-1:0] wd_q, rd_q;
   logic [HOLD_W-1:0] hold_cnt;
   logic wr_q, ack_q, cap_q, done_q, mreq_q, aoe_q, rwn_q, doe_q;
   logic at_wr, at_cap;

   assign at_wr  = tick_stb && ph_hi && (tick == WR_POS);
   assign at_cap = tick_stb && ph_hi && (tick == CAP_POS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         lat_addr <= '0;
         addr_q   <= '0;
         wd_q     <= '0;
         rd_q     <= '0;
         hold_cnt <= '0;
         wr_q     <= 1'b0;
         ack_q    <= 1'b0;
         cap_q    <= 1'b0;
         done_q   <= 1'b0;
         mreq_q   <= 1'b0;
         aoe_q    <= 1'b0;
         rwn_q    <= 1'b1;
         doe_q    <= 1'b0;
      end else begin
         ack_q  <= 1'b0;
         cap_q  <= 1'b0;
         done_q <= cap_q;
         unique case (state)
            S_IDLE: begin
               if (ph_rise && req_valid) begin
                  ack_q    <= 1'b1;
                  mreq_q   <= 1'b1;
                  wr_q     <= req_write;
                  lat_addr <= req_addr;
                  wd_q     <= req_wdata;
                  state    <= S_ARM;
               end
            end
            S_ARM: begin
               if (ph_fall) begin
                  aoe_q  <= 1'b1;
                  addr_q <= lat_addr;
                  rwn_q  <= ~wr_q;
                  state  <= S_SETUP;
               end
            end
            S_SETUP: begin
               if (ph_rise) state <= S_BUS;
            end
            S_BUS: begin
               if (wr_q && at_wr) doe_q <= 1'b1;
               if (at_cap) begin
                  cap_q <= 1'b1;
                  if (!wr_q) rd_q <= bus_rdata;
               end
               if (ph_fall) begin
                  if (HOLD_CLKS == 0) begin
                     doe_q <= 1'b0;
                     aoe_q <= 1'b0;
                     rwn_q <= 1'b1;
                     state <= S_TAIL;
                  end else begin
                     hold_cnt <= HOLD_W'(HOLD_LOAD);
                     state    <= S_HOLD;
                  end
               end
            end
            S_HOLD: begin
               if (hold_cnt == '0) begin
                  doe_q <= 1'b0;
                  aoe_q <= 1'b0;
                  rwn_q <= 1'b1;
                  state <= S_TAIL;
               end else begin
                  hold_cnt <= hold_cnt - 1'b1;
               end
            end
            S_TAIL: begin
               if (ph_rise) begin
                  mreq_q <= 1'b0;
                  state  <= S_IDLE;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign req_ack  = ack_q;
   assign done     = done_q;
   assign rd_data  = rd_q;
   assign mreq_act = mreq_q;
   assign addr     = addr_q;
   assign addr_oe  = aoe_q;
   assign rw_n     = rwn_q;
   assign wdata    = wd_q;
   assign data_oe  = doe_q;
   assign cap_stb  = cap_q;

   a_r3_addr_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_hi && $past(ph_hi)) |-> ($stable(addr_q) && $stable(aoe_q) && $stable(rwn_q)));

   a_r4_oe_write_only: assert property (@(posedge clk) disable iff (!rst_n)
      doe_q |-> (aoe_q && !rwn_q));

   a_r4_oe_spans_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_fall && $past(doe_q)) |-> doe_q);

   a_r6_done_after_cap: assert property (@(posedge clk) disable iff (!rst_n)
      cap_q |=> done_q);

   a_r6_done_needs_cap: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> $past(cap_q));

   a_r7_ack_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q |-> $past(ph_rise));

   a_r2_addr_under_mreq: assert property (@(posedge clk) disable iff (!rst_n)
      aoe_q |-> mreq_q);

endmodule

// File: rtl/bus_cycle_seq.sv
`timescale 1ns/1ps
module bus_cycle_seq #(
   parameter int ADDR_W        = 16,
   parameter int DATA_W        = 8,
   parameter int CLK_NS        = 4,
   parameter int REF_PERIOD_NS = 140,
   parameter int HALF_TICKS    = 7,
   parameter int WR_TICK       = 1,
   parameter int CAP_TICK      = 6,
   parameter int HOLD_NS       = 80,
   parameter int SYNC_STAGES   = 2,
   parameter bit MREQ_ACT_LOW  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_clk_i,
   input  logic              phase_i,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ack,
   output logic              done_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              bus_mreq,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic              bus_addr_oe,
   output logic              bus_rw_n,
   output logic [DATA_W-1:0] bus_wdata_o,
   output logic              bus_data_oe,
   input  logic [DATA_W-1:0] bus_rdata_i,
   output logic              cap_stb
);
   localparam int TICK_W    = $clog2(HALF_TICKS + 1);
   localparam int HOLD_CLKS = bcs_pkg::ceil_div(HOLD_NS, CLK_NS);
   localparam int LOW_HALF_NS = HALF_TICKS * REF_PERIOD_NS / 2;

   if (CAP_TICK >= HALF_TICKS || WR_TICK >= CAP_TICK) begin : g_bad_ticks
      $error("bus_cycle_seq: need WR_TICK < CAP_TICK < HALF_TICKS");
   end
   if (4 * CLK_NS > REF_PERIOD_NS) begin : g_bad_ratio
      $error("bus_cycle_seq: card clock must be at least 4x the reference clock");
   end
   if ((HOLD_CLKS + SYNC_STAGES + 2) * CLK_NS >= LOW_HALF_NS) begin : g_bad_hold
      $error("bus_cycle_seq: hold margin does not fit in the low half");
   end

   logic [1:0] sync_lvl;
   logic ph_hi, ph_rise, ph_fall, tick_stb, mreq_act;
   logic [TICK_W-1:0] tick;

   bcs_sync #(.N_SIG(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({phase_i, ref_clk_i}),
      .lvl_o   (sync_lvl)
   );

   bcs_phase_track #(.TICK_W(TICK_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_lvl    (sync_lvl[0]),
      .ph_lvl     (sync_lvl[1]),
      .ph_hi      (ph_hi),
      .ph_rise    (ph_rise),
      .ph_fall    (ph_fall),
      .tick_o     (tick),
      .tick_stb_o (tick_stb)
   );

   bcs_cycle_fsm #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .TICK_W    (TICK_W),
      .WR_TICK   (WR_TICK),
      .CAP_TICK  (CAP_TICK),
      .HOLD_CLKS (HOLD_CLKS)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .ph_hi     (ph_hi),
      .ph_rise   (ph_rise),
      .ph_fall   (ph_fall),
      .tick      (tick),
      .tick_stb  (tick_stb),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .bus_rdata (bus_rdata_i),
      .req_ack   (req_ack),
      .done      (done_o),
      .rd_data   (rd_data_o),
      .mreq_act  (mreq_act),
      .addr      (bus_addr_o),
      .addr_oe   (bus_addr_oe),
      .rw_n      (bus_rw_n),
      .wdata     (bus_wdata_o),
      .data_oe   (bus_data_oe),
      .cap_stb   (cap_stb)
   );

   if (MREQ_ACT_LOW) begin : g_mreq_low
      assign bus_mreq = ~mreq_act;
   end else begin : g_mreq_high
      assign bus_mreq = mreq_act;
   end

   a_r2_mreq_idle_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_mreq == MREQ_ACT_LOW) |-> (!bus_addr_oe && !bus_data_oe));

endmodule

// File: tb/bus_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module bus_cycle_seq_tb_top;

   localparam int AW = 16;
   localparam int DW = 8;
   localparam int REF_HALF = 32;

   typedef struct packed {
      logic          wr;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_clk = 1'b0;
   logic phase = 1'b0;
   logic req_valid = 1'b0;
   logic req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [DW-1:0] bus_rdata = '0;
   logic req_ack, done_o, bus_mreq, bus_addr_oe, bus_rw_n, bus_data_oe, cap_stb;
   logic [DW-1:0] rd_data_o, bus_wdata_o;
   logic [AW-1:0] bus_addr_o;

   int n_tests = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   time last_rise = 0;
   bit cap_prev = 1'b0;
   bit rise_addr_ok = 1'b0;
   logic [AW-1:0] rise_addr = '0;
   item_t sb_q[$];
   item_t act_item = '0;
   logic [DW-1:0] dev_mem [logic [AW-1:0]];
   logic [DW-1:0] ref_mem [logic [AW-1:0]];

   always #2 clk = ~clk;

   bus_cycle_seq #(.CLK_NS(4), .REF_PERIOD_NS(2*REF_HALF)) dut_i (
      .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .phase_i(phase),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_ack(req_ack), .done_o(done_o),
      .rd_data_o(rd_data_o), .bus_mreq(bus_mreq), .bus_addr_o(bus_addr_o),
      .bus_addr_oe(bus_addr_oe), .bus_rw_n(bus_rw_n), .bus_wdata_o(bus_wdata_o),
      .bus_data_oe(bus_data_oe), .bus_rdata_i(bus_rdata), .cap_stb(cap_stb)
   );

   function automatic logic [DW-1:0] dflt(input logic [AW-1:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   // Bus device: read data valid from 60 ns after the rise, complemented at the fall.
   task automatic on_rise();
      last_rise = $time;
      rise_addr_ok = 1'b0;
      if (bus_addr_oe) begin
         rise_addr = bus_addr_o;
         rise_addr_ok = 1'b1;
      end
      if (bus_addr_oe && bus_rw_n) begin
         fork
            begin
               logic [AW-1:0] a;
               a = bus_addr_o;
               #60 bus_rdata = dev_mem.exists(a) ? dev_mem[a] : dflt(a);
            end
         join_none
      end
   endtask

   task automatic on_fall();
      if (rise_addr_ok)  // R3: address held across the whole high half
         check(bus_addr_oe && bus_addr_o == rise_addr, "R3", bus_addr_o, rise_addr);
      if (rise_addr_ok && bus_rw_n)  // R4: no data drive on a read
         check(!bus_data_oe, "R4", bus_data_oe, 0);
      bus_rdata = ~bus_rdata;
      if (bus_addr_oe && !bus_rw_n && bus_data_oe) begin
         dev_mem[bus_addr_o] = bus_wdata_o;
         check(bus_wdata_o == act_item.d, "R9", bus_wdata_o, act_item.d);
         check(bus_addr_o == act_item.a, "R9", bus_addr_o, act_item.a);
         fork
            begin #80  check(bus_data_oe == 1'b1, "R4", bus_data_oe, 1); end
            begin #150 check(bus_data_oe == 1'b0, "R4", bus_data_oe, 0); end
         join_none
      end
   endtask

   initial begin
      int cnt;
      cnt = 0;
      forever begin
         #(REF_HALF);
         ref_clk = ~ref_clk;
         cnt++;
         if (cnt == 7) begin
            cnt = 0;
            phase = ~phase;
            if (phase) on_rise();
            else       on_fall();
         end
      end
   end

   // R2: request line moves only shortly after a phase rise
   always @(bus_mreq) begin
      if (rst_n && !finished)
         check(($time - last_rise) <= 200, "R2", $time - last_rise, 200);
   end

   // R1: write enable opens at position 1 of the high half
   always @(posedge bus_data_oe) begin
      check(phase && ($time - last_rise) >= REF_HALF && ($time - last_rise) < 2*REF_HALF,
            "R1", $time - last_rise, REF_HALF);
   end

   // Monitor: strobe position, ack timing, scoreboard pop
   always @(negedge clk) begin
      if (rst_n) begin
         if (cap_stb)  // R1: sample strobe at position 6
            check(phase && ($time - last_rise) >= 6*REF_HALF && ($time - last_rise) < 7*REF_HALF,
                  "R1", $time - last_rise, 6*REF_HALF);
         if (req_ack) begin  // R7: accepted only right after a rise
            check(($time - last_rise) < 40 && phase, "R7", $time - last_rise, 40);
            if (sb_q.size() > 0) act_item = sb_q[0];
         end
         if (done_o) begin
            check(cap_prev, "R6", cap_prev, 1);
            if (sb_q.size() == 0) begin
               check(1'b0, "R6", 0, 1);
            end else begin
               item_t it;
               it = sb_q.pop_front();
               if (!it.wr) check(rd_data_o == it.d, "R5", rd_data_o, it.d);
            end
         end
         cap_prev = cap_stb;
      end
   end

   task automatic do_op(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
      item_t it;
      @(negedge clk);
      it.wr = wr;
      it.a  = a;
      if (wr) begin
         ref_mem[a] = d;
         it.d = d;
      end else begin
         it.d = ref_mem.exists(a) ? ref_mem[a] : dflt(a);
      end
      sb_q.push_back(it);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      do @(negedge clk); while (!req_ack);
      req_valid = 1'b0;
   endtask

   initial begin
      #21 rst_n = 1'b1;
      #9;
      // R8: reset state
      check(bus_mreq == 1'b1, "R8", bus_mreq, 1);
      check(bus_addr_oe == 1'b0, "R8", bus_addr_oe, 0);
      check(bus_data_oe == 1'b0, "R8", bus_data_oe, 0);
      check(bus_rw_n == 1'b1, "R8", bus_rw_n, 1);
      check(req_ack == 1'b0 && done_o == 1'b0, "R8", {req_ack, done_o}, 0);
      // R7: first request raised in the middle of a high half
      wait (phase == 1'b1);
      #50;
      do_op(1'b1, 16'h1234, 8'hA5);
      do_op(1'b1, 16'h8001, 8'h3C);
      do_op(1'b0, 16'h1234, 8'h00);
      do_op(1'b0, 16'h8001, 8'h00);
      do_op(1'b0, 16'h4477, 8'h00);
      do_op(1'b1, 16'h4477, 8'h00);
      do_op(1'b1, 16'h00FF, 8'hFF);
      do_op(1'b0, 16'h4477, 8'h00);
      do_op(1'b0, 16'h00FF, 8'h00);
      do_op(1'b0, 16'h1234, 8'h00);
      wait (sb_q.size() == 0);
      repeat (400) @(negedge clk);
      check(bus_mreq == 1'b1, "R2", bus_mreq, 1);
      check(bus_addr_oe == 1'b0 && bus_data_oe == 1'b0, "R3", {bus_addr_oe, bus_data_oe}, 0);
      finish_run();
   end

   initial begin
      #200000;
      n_tests++;
      n_fail++;
      $display("FAIL R7: watchdog expired, actual %0d pending expected 0", sb_q.size());
      finish_run();
   end

endmodule